// File: doc/BRIEF.md
# Bidirectional Ring Stop

One node of a four-node ring that carries memory read data from the stop that owns the addressed memory to the stop nearest the requesting client. Each stop owns two independent memory channels, so the ring has eight in all. Two rings run in opposite directions, and each stop has one registered output link per direction. A request address is decoded to its owning stop and channel. The owning stop takes the returned data from its two channels and sends it either straight to its own cache port or onto the ring. The data then moves one stop per cycle until it reaches its destination, where it is handed to the local cache port.

Every flit carries a 2-bit destination stop ID, a tag and a data line. A stop pulls off the ring every flit addressed to itself. It forwards every other flit unchanged on the same ring. Flits already on the ring always win over new data from the local channels, so traffic in flight is never held back by injection.

Top module: `ring_stop`

## Requirements
- R1: The owning stop of `req_addr` is bits [INTLV_LSB+2:INTLV_LSB+1] and the channel within that stop is bit INTLV_LSB. `req_local` is 1 exactly when the owning stop equals this stop's ID.
- R2: Returned data with destination D at stop S uses hop distance (D-S) mod 4. Distance 1 or 2 goes out on the clockwise ring (index 0). Distance 3 goes out on the counter-clockwise ring (index 1). The tie at distance 2 always picks clockwise.
- R3: Returned data whose destination is this stop (distance 0) is accepted and shown on `ej_loc_*` in the same cycle. It never enters the ring.
- R4: A ring input flit whose destination is not this stop is accepted when the same-direction output register is empty or being drained. It then appears on that output the next cycle with destination, tag and data unchanged.
- R5: A ring input flit whose destination is this stop is always accepted (`rin_rdy` high). It is shown on `ej_ring_*` of that direction in the same cycle and is not forwarded.
- R6: A pass-through flit takes the output slot before any local injection into the same direction. The local channel sees `mem_rdy` low in that cycle and is injected in a later free cycle.
- R7: While an output link is valid and its `rout_rdy` is low, the output holds its flit unchanged. A pass-through flit for that direction then sees `rin_rdy` low.
- R8: When both channels want the same resource (one ring direction, or the local port), channel 0 wins. When they want different resources, both are accepted in the same cycle.
- R9: While reset is asserted, both ring outputs are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_addr | input | ADDR_W | Request address to decode |
| req_owner | output | 2 | Stop that owns the address |
| req_chan | output | 1 | Channel within the owning stop |
| req_local | output | 1 | Owning stop is this stop |
| mem_vld | input | 2 | Returned data valid, one bit per local channel |
| mem_rdy | output | 2 | Returned data accepted, per channel |
| mem_dst | input | 2x2 | Requester stop ID, per channel |
| mem_tag | input | 2xTAG_W | Request tag, per channel |
| mem_data | input | 2xDATA_W | Data line, per channel |
| rin_vld | input | 2 | Ring input valid (0 clockwise, 1 counter-clockwise) |
| rin_rdy | output | 2 | Ring input ready |
| rin_dst | input | 2x2 | Ring input destination stop |
| rin_tag | input | 2xTAG_W | Ring input tag |
| rin_data | input | 2xDATA_W | Ring input data |
| rout_vld | output | 2 | Ring output valid |
| rout_rdy | input | 2 | Ring output ready from the next stop |
| rout_dst | output | 2x2 | Ring output destination stop |
| rout_tag | output | 2xTAG_W | Ring output tag |
| rout_data | output | 2xDATA_W | Ring output data |
| ej_ring_vld | output | 2 | Flit ejected from each ring to the cache |
| ej_ring_tag | output | 2xTAG_W | Ejected ring flit tag |
| ej_ring_data | output | 2xDATA_W | Ejected ring flit data |
| ej_loc_vld | output | 1 | Local channel data delivered to the cache |
| ej_loc_tag | output | TAG_W | Local delivery tag |
| ej_loc_data | output | DATA_W | Local delivery data |

## Verification
The checks on output direction take for granted that ring inputs come from legal neighbours. A clockwise input flit must be one or two hops from its sender, so its destination is this stop or the next stop clockwise. A counter-clockwise input flit must always be addressed to this stop. The bench drives only such flits on the ring inputs. It changes inputs only away from the clock edge and keeps a stalled output's ready low for whole cycles, so the hold and forwarding checks see clean handshakes.

// File: rtl/ring_stop.sv
module ring_stop #(
  parameter int NODE_ID   = 0,
  parameter int ADDR_W    = 32,
  parameter int INTLV_LSB = 8,
  parameter int TAG_W     = 8,
  parameter int DATA_W    = 256
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            req_addr,
  output logic [1:0]                   req_owner,
  output logic                         req_chan,
  output logic                         req_local,
  input  logic [1:0]                   mem_vld,
  output logic [1:0]                   mem_rdy,
  input  logic [1:0][1:0]              mem_dst,
  input  logic [1:0][TAG_W-1:0]        mem_tag,
  input  logic [1:0][DATA_W-1:0]       mem_data,
  input  logic [1:0]                   rin_vld,
  output logic [1:0]                   rin_rdy,
  input  logic [1:0][1:0]              rin_dst,
  input  logic [1:0][TAG_W-1:0]        rin_tag,
  input  logic [1:0][DATA_W-1:0]       rin_data,
  output logic [1:0]                   rout_vld,
  input  logic [1:0]                   rout_rdy,
  output logic [1:0][1:0]              rout_dst,
  output logic [1:0][TAG_W-1:0]        rout_tag,
  output logic [1:0][DATA_W-1:0]       rout_data,
  output logic [1:0]                   ej_ring_vld,
  output logic [1:0][TAG_W-1:0]        ej_ring_tag,
  output logic [1:0][DATA_W-1:0]       ej_ring_data,
  output logic                         ej_loc_vld,
  output logic [TAG_W-1:0]             ej_loc_tag,
  output logic [DATA_W-1:0]            ej_loc_data
);

  localparam logic [1:0] MY = 2'(NODE_ID);

  logic [1:0][1:0] hop;
  logic [1:0]      want_loc;
  logic [1:0][1:0] want;
  logic [1:0][1:0] grant;
  logic [1:0]      gl;
  logic [1:0]      space, own_in, pass;

  assign req_owner = req_addr[INTLV_LSB+1 +: 2];
  assign req_chan  = req_addr[INTLV_LSB];
  assign req_local = (req_owner == MY);

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      hop[c]      = mem_dst[c] - MY;
      want_loc[c] = mem_vld[c] && (hop[c] == 2'd0);
      want[c][0]  = mem_vld[c] && (hop[c] == 2'd1 || hop[c] == 2'd2);
      want[c][1]  = mem_vld[c] && (hop[c] == 2'd3);
    end
    for (int d = 0; d < 2; d++) begin
      space[d]    = !rout_vld[d] || rout_rdy[d];
      own_in[d]   = (rin_dst[d] == MY);
      pass[d]     = rin_vld[d] && !own_in[d];
      grant[0][d] = want[0][d] && space[d] && !pass[d];
      grant[1][d] = want[1][d] && space[d] && !pass[d] && !want[0][d];
    end
    gl[0] = want_loc[0];
    gl[1] = want_loc[1] && !want_loc[0];
    for (int c = 0; c < 2; c++)
      mem_rdy[c] = gl[c] || (|grant[c]);
  end

  assign rin_rdy      = own_in | space;
  assign ej_ring_vld  = rin_vld & own_in;
  assign ej_ring_tag  = rin_tag;
  assign ej_ring_data = rin_data;

  assign ej_loc_vld  = |gl;
  assign ej_loc_tag  = gl[0] ? mem_tag[0]  : mem_tag[1];
  assign ej_loc_data = gl[0] ? mem_data[0] : mem_data[1];

  always_ff @(posedge clk) begin
    if (!rst_n) rout_vld <= '0;
    else
      for (int d = 0; d < 2; d++)
        if (space[d]) rout_vld[d] <= pass[d] || grant[0][d] || grant[1][d];
  end

  always_ff @(posedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (space[d]) begin
        if (pass[d]) begin
          rout_dst[d]  <= rin_dst[d];
          rout_tag[d]  <= rin_tag[d];
          rout_data[d] <= rin_data[d];
        end else if (grant[1][d]) begin
          rout_dst[d]  <= mem_dst[1];
          rout_tag[d]  <= mem_tag[1];
          rout_data[d] <= mem_data[1];
        end else begin
          rout_dst[d]  <= mem_dst[0];
          rout_tag[d]  <= mem_tag[0];
          rout_data[d] <= mem_data[0];
        end
      end
    end
  end

  for (genvar d = 0; d < 2; d++) begin : g_chk
    p_pass_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rin_vld[d] && rin_rdy[d] && rin_dst[d] != MY) |=>
        (rout_vld[d] && rout_dst[d] == $past(rin_dst[d]) && rout_tag[d] == $past(rin_tag[d])
         && rout_data[d] == $past(rin_data[d])));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rout_vld[d] && !rout_rdy[d]) |=>
        (rout_vld[d] && $stable(rout_tag[d]) && $stable(rout_dst[d]) && $stable(rout_data[d])));
    p_eject_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rin_vld[d] && rin_dst[d] == MY) |-> (rin_rdy[d] && ej_ring_vld[d]));
    p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rin_vld[d] && rin_dst[d] != MY && rout_vld[d] && !rout_rdy[d]) |-> !rin_rdy[d]);
  end

  p_cw_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rout_vld[0] |-> (rout_dst[0] == MY + 2'd1 || rout_dst[0] == MY + 2'd2));
  p_ccw_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rout_vld[1] |-> (rout_dst[1] == MY - 2'd1));
  p_local_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_vld[0] && mem_rdy[0] && mem_dst[0] == MY) |-> (ej_loc_vld && ej_loc_tag == mem_tag[0]));
  p_chan_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_vld == 2'b11 && mem_dst[0] == mem_dst[1]) |-> !mem_rdy[1]);
  p_reset_r9: assert property (@(posedge clk)
    !rst_n |=> (rout_vld == 2'b00));

endmodule

// File: tb/test_ring_stop.sv
module test_ring_stop;
  localparam int ID = 1, AW = 32, LSB = 8, TW = 8, DW = 256;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_owner; logic req_chan, req_local;
  logic [1:0] mem_vld = '0, mem_rdy;
  logic [1:0][1:0] mem_dst = '0;
  logic [1:0][TW-1:0] mem_tag = '0;
  logic [1:0][DW-1:0] mem_data = '0;
  logic [1:0] rin_vld = '0, rin_rdy;
  logic [1:0][1:0] rin_dst = '0;
  logic [1:0][TW-1:0] rin_tag = '0;
  logic [1:0][DW-1:0] rin_data = '0;
  logic [1:0] rout_vld, rout_rdy = 2'b11;
  logic [1:0][1:0] rout_dst;
  logic [1:0][TW-1:0] rout_tag;
  logic [1:0][DW-1:0] rout_data;
  logic [1:0] ej_ring_vld;
  logic [1:0][TW-1:0] ej_ring_tag;
  logic [1:0][DW-1:0] ej_ring_data;
  logic ej_loc_vld; logic [TW-1:0] ej_loc_tag; logic [DW-1:0] ej_loc_data;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ring_stop #(.NODE_ID(ID), .ADDR_W(AW), .INTLV_LSB(LSB), .TAG_W(TW), .DATA_W(DW)) i_ring_stop (
    .clk, .rst_n, .req_addr, .req_owner, .req_chan, .req_local,
    .mem_vld, .mem_rdy, .mem_dst, .mem_tag, .mem_data,
    .rin_vld, .rin_rdy, .rin_dst, .rin_tag, .rin_data,
    .rout_vld, .rout_rdy, .rout_dst, .rout_tag, .rout_data,
    .ej_ring_vld, .ej_ring_tag, .ej_ring_data, .ej_loc_vld, .ej_loc_tag, .ej_loc_data);

  // path code: 0 local, 1 clockwise, 2 counter-clockwise (stop ID 1)
  localparam int NV = 8;
  localparam logic [31:0] T_ADDR [NV] = '{32'h0000_0000, 32'h0000_0100, 32'h0000_0200, 32'h0000_0300,
                                          32'h0000_0400, 32'h0000_0500, 32'h0000_0600, 32'h0000_07FF};
  localparam logic [1:0] T_OWN [NV] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3, 2'd3};
  localparam logic       T_CH  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [1:0] T_DST [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd3, 2'd2, 2'd1, 2'd0};
  localparam logic [1:0] T_PATH[NV] = '{2'd2, 2'd0, 2'd1, 2'd1, 2'd1, 2'd1, 2'd0, 2'd2};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset outputs", {62'd0, rout_vld}, 64'd0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_addr = T_ADDR[i];
      mem_vld[0] = 1; mem_dst[0] = T_DST[i]; mem_tag[0] = 8'h10 + 8'(i); mem_data[0] = DW'(i * 7 + 3);
      #1;
      chk("R1 owner", {62'd0, req_owner}, {62'd0, T_OWN[i]});
      chk("R1 chan", {63'd0, req_chan}, {63'd0, T_CH[i]});
      chk("R1 local", {63'd0, req_local}, {63'd0, T_OWN[i] == 2'(ID)});
      chk("R3 accept", {63'd0, mem_rdy[0]}, 64'd1);
      chk("R3 local deliver", {63'd0, ej_loc_vld}, {63'd0, T_PATH[i] == 2'd0});
      if (T_PATH[i] == 2'd0) chk("R3 local tag", {56'd0, ej_loc_tag}, {56'd0, 8'h10 + 8'(i)});
      @(posedge clk); @(negedge clk);
      mem_vld = '0;
      chk("R2 cw valid", {63'd0, rout_vld[0]}, {63'd0, T_PATH[i] == 2'd1});
      chk("R2 ccw valid", {63'd0, rout_vld[1]}, {63'd0, T_PATH[i] == 2'd2});
      if (T_PATH[i] == 2'd1) chk("R2 cw tag", {56'd0, rout_tag[0]}, {56'd0, 8'h10 + 8'(i)});
      if (T_PATH[i] == 2'd2) chk("R2 ccw tag", {56'd0, rout_tag[1]}, {56'd0, 8'h10 + 8'(i)});
    end
    @(posedge clk); @(negedge clk);

    // R4 pass-through on clockwise ring
    rin_vld[0] = 1; rin_dst[0] = 2'd2; rin_tag[0] = 8'hA1; rin_data[0] = DW'(64'hDEAD);
    #1 chk("R4 pass accept", {63'd0, rin_rdy[0]}, 64'd1);
    chk("R4 no eject", {62'd0, ej_ring_vld}, 64'd0);
    @(posedge clk); @(negedge clk);
    rin_vld = '0;
    chk("R4 forwarded", {63'd0, rout_vld[0]}, 64'd1);
    chk("R4 tag", {56'd0, rout_tag[0]}, 64'hA1);
    chk("R4 dst", {62'd0, rout_dst[0]}, 64'd2);
    chk("R4 data", rout_data[0][63:0], 64'hDEAD);

    // R5 ejection from counter-clockwise ring
    rin_vld[1] = 1; rin_dst[1] = 2'(ID); rin_tag[1] = 8'hB2;
    #1 chk("R5 eject valid", {62'd0, ej_ring_vld}, 64'b10);
    chk("R5 eject tag", {56'd0, ej_ring_tag[1]}, 64'hB2);
    chk("R5 ready", {63'd0, rin_rdy[1]}, 64'd1);
    @(posedge clk); @(negedge clk);
    rin_vld = '0;
    chk("R5 not forwarded", {63'd0, rout_vld[1]}, 64'd0);

    // R6 ring traffic beats injection
    rin_vld[0] = 1; rin_dst[0] = 2'd2; rin_tag[0] = 8'hC3;
    mem_vld[0] = 1; mem_dst[0] = 2'd3; mem_tag[0] = 8'hC4;
    #1 chk("R6 inject held", {63'd0, mem_rdy[0]}, 64'd0);
    @(posedge clk); @(negedge clk);
    rin_vld = '0;
    chk("R6 ring flit first", {56'd0, rout_tag[0]}, 64'hC3);
    #1 chk("R6 inject later", {63'd0, mem_rdy[0]}, 64'd1);
    @(posedge clk); @(negedge clk);
    mem_vld = '0;
    chk("R6 injected flit", {56'd0, rout_tag[0]}, 64'hC4);

    // R8 channel contention and independence
    mem_vld = 2'b11; mem_dst[0] = 2'd2; mem_dst[1] = 2'd3; mem_tag[0] = 8'hD0; mem_tag[1] = 8'hD1;
    #1 chk("R8 cw contention", {62'd0, mem_rdy}, 64'b01);
    @(posedge clk); @(negedge clk);
    mem_dst[0] = 2'(ID); mem_dst[1] = 2'd0; mem_tag[0] = 8'hE0; mem_tag[1] = 8'hE1;
    #1 chk("R8 independent", {62'd0, mem_rdy}, 64'b11);
    chk("R8 local tag", {56'd0, ej_loc_tag}, 64'hE0);
    @(posedge clk); @(negedge clk);
    chk("R8 ccw carries ch1", {56'd0, rout_tag[1]}, 64'hE1);
    mem_dst[0] = 2'(ID); mem_dst[1] = 2'(ID); mem_tag[0] = 8'hF0; mem_tag[1] = 8'hF1;
    #1 chk("R8 local contention", {62'd0, mem_rdy}, 64'b01);
    chk("R8 local winner", {56'd0, ej_loc_tag}, 64'hF0);
    @(posedge clk); @(negedge clk);
    mem_vld = '0;
    @(posedge clk); @(negedge clk);

    // R7 back-pressure
    rout_rdy[0] = 0;
    mem_vld[0] = 1; mem_dst[0] = 2'd2; mem_tag[0] = 8'h55;
    #1 chk("R7 empty accepts", {63'd0, mem_rdy[0]}, 64'd1);
    @(posedge clk); @(negedge clk);
    mem_vld = '0;
    chk("R7 loaded", {56'd0, rout_tag[0]}, 64'h55);
    rin_vld[0] = 1; rin_dst[0] = 2'd2; rin_tag[0] = 8'h66;
    #1 chk("R7 pass blocked", {63'd0, rin_rdy[0]}, 64'd0);
    @(posedge clk); @(negedge clk);
    chk("R7 held valid", {63'd0, rout_vld[0]}, 64'd1);
    chk("R7 held tag", {56'd0, rout_tag[0]}, 64'h55);
    rout_rdy[0] = 1;
    #1 chk("R7 released", {63'd0, rin_rdy[0]}, 64'd1);
    @(posedge clk); @(negedge clk);
    rin_vld = '0;
    chk("R7 next flit", {56'd0, rout_tag[0]}, 64'h66);
    @(posedge clk); @(negedge clk);
    chk("R7 drained", {63'd0, rout_vld[0]}, 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule